// File: doc/BRIEF.md
# Block Carry-Lookahead Adder

This block is a purely combinational adder. It takes two operands of equal width and a carry-in, and returns their sum together with a carry-out. The operand width is split into four-bit slices. Inside each slice, the sum bits come from a short ripple chain of full adders. A separate unit also works out, for each slice, whether the slice creates a carry on its own (group generate) and whether it would pass an incoming carry straight through (group propagate). These two terms depend only on the operand bits of that slice. The carry into the next slice is therefore one AND-OR of the slice's generate, its propagate and its own incoming carry. The carry does not wait for the slice's bits to ripple.

The block suits any datapath that needs a single-cycle add wider than a plain ripple chain can close in time. The width is a parameter and must be a whole multiple of four; any other value stops elaboration. The block has no registers, so results follow the inputs within the same cycle.

Top module: `cla_adder`

## Requirements
- R1: `sumOut` equals the low WIDTH bits of the arithmetic sum opA + opB + carryIn, for any operands. With all inputs zero, both outputs are zero.
- R2: `carryOut` equals bit WIDTH of that same arithmetic sum, which is the carry leaving the most significant four-bit slice.
- R3: `carryIn` enters at bit 0. When opA is all ones and opB is zero, `sumOut` is zero and `carryOut` is 1 if carryIn is 1. `sumOut` is all ones and `carryOut` is 0 if carryIn is 0.
- R4: This requirement covers the case where every bit position propagates without generating: opA | opB is all ones and opA & opB is zero. In that case the incoming carry passes through every slice unchanged. `carryOut` equals `carryIn`, and every bit of `sumOut` equals the inverse of `carryIn`.
- R5: A carry created inside a slice reaches the next slice's lowest bit. For example, 0x0000000F + 0x00000001 gives 0x00000010, and 0x0000FFFF + 0x00000001 gives 0x00010000. When bit WIDTH-1 of both operands is 1, `carryOut` is 1 whatever the other inputs are.
- R6: When both operands are all ones and carryIn is 1, `sumOut` is all ones and `carryOut` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Low WIDTH bits of the sum |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The block holds no state, so a wrong group generate or propagate term shows up on `sumOut` or `carryOut` as soon as the inputs change. The error appears only for operand patterns that push a carry across the affected slice boundary. For that reason the stimulus includes cases where a carry must travel through long runs of propagating slices, cases where a slice creates a carry at its top bit, and cases where carryIn alone decides every output bit. A fault in a slice's internal ripple shows up only in that slice's sum bits, and only when a carry crosses the faulty position.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Width of one lookahead slice; the group equations are written for it.
  localparam int unsigned BLK_W = 4;

  // Group terms a slice hands to the inter-slice carry chain.
  typedef struct packed {
    logic gen;
    logic prop;
  } blkGp_t;
endpackage

// File: rtl/cla_block_pg.sv
module cla_block_pg
  import cla_pkg::*;
(
  input  logic [BLK_W-1:0] aBits,
  input  logic [BLK_W-1:0] bBits,
  output blkGp_t           gp
);
  logic [BLK_W-1:0] colGen;
  logic [BLK_W-1:0] colProp;

  assign colGen  = aBits & bBits;
  assign colProp = aBits | bBits;

  // Group generate folds from the lowest column upward; no carry-in involved.
  always_comb begin
    gp.gen = 1'b0;
    for (int i = 0; i < BLK_W; i++) begin
      gp.gen = colGen[i] | (colProp[i] & gp.gen);
    end
    gp.prop = &colProp;
  end
endmodule

// File: rtl/cla_block_ripple.sv
module cla_block_ripple
  import cla_pkg::*;
(
  input  logic [BLK_W-1:0] aBits,
  input  logic [BLK_W-1:0] bBits,
  input  logic             blkCin,
  output logic [BLK_W-1:0] sumBits
);
  // Internal carries; the slice's own carry-out comes from the lookahead chain.
  logic [BLK_W-1:0] rippleC;

  assign rippleC[0] = blkCin;

  for (genvar i = 0; i < BLK_W; i++) begin : g_col
    assign sumBits[i] = aBits[i] ^ bBits[i] ^ rippleC[i];
    if (i < BLK_W - 1) begin : g_next
      assign rippleC[i+1] = (aBits[i] & bBits[i]) | ((aBits[i] | bBits[i]) & rippleC[i]);
    end
  end
endmodule

// File: rtl/cla_carry_chain.sv
module cla_carry_chain
  import cla_pkg::*;
#(
  parameter int unsigned NUM_BLK = 8
) (
  input  blkGp_t [NUM_BLK-1:0] gpVec,
  input  logic                 chainCin,
  output logic [NUM_BLK:0]     blkCarry
);
  assign blkCarry[0] = chainCin;

  // One AND-OR per slice boundary.
  for (genvar k = 0; k < NUM_BLK; k++) begin : g_hop
    assign blkCarry[k+1] = gpVec[k].gen | (gpVec[k].prop & blkCarry[k]);
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int unsigned NUM_BLK = WIDTH / BLK_W;

  if ((WIDTH % BLK_W) != 0 || WIDTH == 0) begin : g_widthCheck
    $error("cla_adder: WIDTH must be a nonzero multiple of the slice width");
  end

  blkGp_t [NUM_BLK-1:0] gpVec;
  logic   [NUM_BLK:0]   blkCarry;

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    cla_block_pg u_pg (
      .aBits (opA[k*BLK_W +: BLK_W]),
      .bBits (opB[k*BLK_W +: BLK_W]),
      .gp    (gpVec[k])
    );

    cla_block_ripple u_rip (
      .aBits   (opA[k*BLK_W +: BLK_W]),
      .bBits   (opB[k*BLK_W +: BLK_W]),
      .blkCin  (blkCarry[k]),
      .sumBits (sumOut[k*BLK_W +: BLK_W])
    );
  end

  cla_carry_chain #(.NUM_BLK(NUM_BLK)) u_chain (
    .gpVec    (gpVec),
    .chainCin (carryIn),
    .blkCarry (blkCarry)
  );

  assign carryOut = blkCarry[NUM_BLK];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut
);
  logic [WIDTH:0] refSum;
  assign refSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    p_sum_match_r1: assert (sumOut == refSum[WIDTH-1:0])
      else $error("R1 sum mismatch");
    p_cout_match_r2: assert (carryOut == refSum[WIDTH])
      else $error("R2 carry-out mismatch");
    if (opA == '1 && opB == '0) begin
      p_cin_entry_r3: assert (carryOut == carryIn && sumOut == {WIDTH{~carryIn}})
        else $error("R3 carry-in entry wrong");
    end
    if ((opA | opB) == '1 && (opA & opB) == '0) begin
      p_full_prop_r4: assert (carryOut == carryIn && sumOut == {WIDTH{~carryIn}})
        else $error("R4 propagate run wrong");
    end
    if (opA[WIDTH-1] && opB[WIDTH-1]) begin
      p_top_gen_r5: assert (carryOut)
        else $error("R5 top generate lost");
    end
    if (opA == '1 && opB == '1 && carryIn) begin
      p_all_gen_r6: assert (carryOut && sumOut == '1)
        else $error("R6 all-ones case wrong");
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) i_chk (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .sumOut   (sumOut),
  .carryOut (carryOut)
);

// File: tb/test_cla_adder.sv
`timescale 1ns/1ps
module test_cla_adder;
  localparam int unsigned W = 32;

  typedef struct {
    logic [W:0] expVal;
    string      tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int    checks = 0;
  int    errors = 0;
  bit    driveDone = 1'b0;
  item_t sb[$];

  always #2.5 clk = ~clk;

  cla_adder #(.WIDTH(W)) i_cla_adder (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input string tag);
    item_t it;
    @(posedge clk);
    opA     <= a;
    opB     <= b;
    carryIn <= c;
    it.expVal = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    it.tag    = tag;
    sb.push_back(it);
  endtask

  // Monitor: inputs change just after a rising edge, outputs read at the falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if ({carryOut, sumOut} != it.expVal) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, {carryOut, sumOut}, it.expVal);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    drive('0, '0, 1'b0, "R1 reset state zero inputs");
    drive('0, '0, 1'b1, "R1 zero plus carry-in");
    drive(32'h1234_5678, 32'h8765_4321, 1'b0, "R1 mixed operands");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R2 wrap to carry-out");
    drive(32'hFFFF_FFFF, '0, 1'b1, "R3 carry-in through all ones");
    drive(32'hFFFF_FFFF, '0, 1'b0, "R3 no carry-in all ones");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R4 propagate run cin0");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R4 propagate run cin1");
    drive(32'hF0F0_0F0F, 32'h0F0F_F0F0, 1'b1, "R4 propagate slices cin1");
    drive(32'h0000_000F, 32'h0000_0001, 1'b0, "R5 slice boundary carry");
    drive(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R5 carry across four slices");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R5 top generate");
    drive(32'h0FFF_FFF8, 32'h0000_0008, 1'b0, "R5 generate then long propagate");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6 all ones both with cin");
    for (int i = 0; i < 60; i++) begin
      drive(W'($urandom), W'($urandom), 1'($urandom), "R1 R2 random");
    end
    @(posedge clk);
    @(posedge clk);
    driveDone = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!(driveDone && sb.size() == 0) && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule